// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block turns a CPU wait strobe into one of four low-power states and brings the chip back out again. At the moment of the strobe it reads the standby controls, the module-stop contents, the oscillation-stop-detect enable and the voltage-monitor reset selections. From these it picks light sleep, all-module clock stop, software standby or deep standby, or it refuses the request. It drives the CPU clock gate, the peripheral clock gate, the oscillator enable and the core power enable to match the chosen state.

Wake-up depends on the state. Sleep and all-module clock stop return at once on a qualified interrupt. Software standby first restarts the oscillators and waits a programmed settling count. Deep standby wakes only through a set of edge-detected sources that latch into flags. When an enabled flag is set, the block restores core power, pulses a deep-standby reset and records the cause. An I/O-hold output keeps the pads frozen while in deep standby. If the keep bit is set, the hold also lasts past the reset until software clears that bit.

Top module: `lpm_seq`

## Requirements
- R1: A wait strobe in run state with `sby_i`=0 enters sleep one cycle later: CPU clock gate 0, peripheral clock, oscillator and core power 1. `dsby_i` is ignored while `sby_i`=0, and `ostd_en_i` does not block sleep.
- R2: With `sby_i`=0, the wait enters all-module clock stop (CPU and peripheral clocks 0, oscillator and power 1) only when `acs_en_i`=1, `mstop_b_i` is all ones and `mstop_c_hi_i` is all ones. If any one of these is missing, it enters sleep.
- R3: With `sby_i`=1 and `dsby_i`=0, the wait enters software standby: CPU clock, peripheral clock and oscillator 0, core power 1.
- R4: With `sby_i`=1 and `ostd_en_i`=1, the wait strobe is ignored and the block stays in run state.
- R5: With `sby_i`=1 and `dsby_i`=1, the wait enters deep standby, where all four enables are 0 and `io_hold_o`=1. If `vm1_rst_sel_i` or `vm2_rst_sel_i` is 1, the block enters software standby instead.
- R6: An interrupt request with its `irq_masked_i` bit at 1 does not wake sleep, all-module clock stop or software standby. An unmasked request wakes sleep to run state one cycle later.
- R7: In all-module clock stop, an unmasked request whose `irq_to_dma_i` bit is 1 does not wake the block. The same request with that bit at 0 wakes it.
- R8: An unmasked interrupt in software standby turns the oscillator on at once. It then holds the CPU clock off for `stab_cnt_i`+1 cycles before returning to run state.
- R9: Each `ds_src_i` bit passes through a two-flop synchronizer. Its flag in `ds_flag_o` is set three clock edges after the pin changes, on the edge chosen by `ds_edge_i` (0 = falling, 1 = rising). The opposite edge sets nothing, and a `ds_flag_clr_i` bit clears its flag.
- R10: Deep standby is cancelled only when a set flag has its `ds_en_i` bit at 1. On cancel, the next cycle has core power and oscillator at 1, `ds_rst_o` high for RST_LEN cycles and `ds_cause_o` set. Run state follows.
- R11: When the keep bit (written through `iokeep_wr_i`/`iokeep_wd_i`) is 1 at deep-standby cancel, `io_hold_o` stays 1 through the reset and afterwards. The deep-standby reset does not clear the bit. Writing the bit to 0 drops the hold one cycle later.
- R12: `rst_req_i` returns the block from any low-power state to run state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wait_i | input | 1 | CPU wait strobe |
| sby_i | input | 1 | Standby select bit |
| dsby_i | input | 1 | Deep standby select bit |
| acs_en_i | input | 1 | All-module clock stop enable |
| mstop_b_i | input | MSB_W | Module-stop register B contents |
| mstop_c_hi_i | input | MSC_HI_W | Upper half of module-stop register C |
| ostd_en_i | input | 1 | Oscillation-stop-detect enable |
| vm1_rst_sel_i | input | 1 | Voltage monitor 1 reset function selected |
| vm2_rst_sel_i | input | 1 | Voltage monitor 2 reset function selected |
| irq_req_i | input | NIRQ | Interrupt requests |
| irq_masked_i | input | NIRQ | Per-request CPU mask status |
| irq_to_dma_i | input | NIRQ | Per-request routing to DMA/data transfer |
| rst_req_i | input | 1 | Reset request from any reset source |
| stab_cnt_i | input | CNT_W | Oscillator settling count |
| ds_src_i | input | NDS | Deep standby wake source pins |
| ds_edge_i | input | NDS | Edge select per source, 1 = rising |
| ds_en_i | input | NDS | Deep standby cancel enable per source |
| ds_flag_clr_i | input | NDS | Flag clear strobes |
| ds_cause_clr_i | input | 1 | Clears the deep-standby cause flag |
| iokeep_wr_i | input | 1 | Write strobe for the keep bit |
| iokeep_wd_i | input | 1 | Keep bit write value |
| cpu_clk_en_o | output | 1 | CPU clock gate |
| per_clk_en_o | output | 1 | Peripheral clock gate |
| osc_en_o | output | 1 | Oscillator enable |
| core_pwr_en_o | output | 1 | Core power enable |
| ds_rst_o | output | 1 | Deep-standby reset request |
| io_hold_o | output | 1 | I/O state hold |
| ds_cause_o | output | 1 | Deep-standby cause flag |
| ds_flag_o | output | NDS | Wake source flags |

## Verification
The four enables come straight from the state register. They therefore change one edge after the edge that samples a wait strobe, an interrupt or `rst_req_i`, and the bench reads them 1 ns after that edge. A wake source pin sets its flag on the third edge after it is driven and starts the reset pulse on the fourth. The pulse then lasts RST_LEN samples, and software standby settling lasts `stab_cnt_i`+1 samples. The bench checks the value before and after each of these boundaries. Cases where a pin, interrupt or strobe should have no effect are checked by reading the gates or flags after enough edges have passed that an effect would already be visible.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_AMCS, ST_SSBY, ST_SSTAB, ST_DSBY, ST_DSRST
  } lpm_state_e;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_SLEEP, TGT_AMCS, TGT_SSBY, TGT_DSBY
  } lpm_tgt_e;
endpackage

// File: rtl/lpm_select.sv
module lpm_select import lpm_pkg::*; #(
  parameter int MSB_W    = 32,
  parameter int MSC_HI_W = 16
) (
  input  logic                sby,
  input  logic                dsby,
  input  logic                acs_en,
  input  logic [MSB_W-1:0]    mstop_b,
  input  logic [MSC_HI_W-1:0] mstop_c_hi,
  input  logic                ostd_en,
  input  logic                vm1_sel,
  input  logic                vm2_sel,
  output lpm_tgt_e            tgt
);
  logic all_stopped;
  assign all_stopped = acs_en && (&mstop_b) && (&mstop_c_hi);

  always_comb begin
    if (!sby)                     tgt = all_stopped ? TGT_AMCS : TGT_SLEEP;
    else if (ostd_en)             tgt = TGT_NONE;
    else if (dsby && !(vm1_sel || vm2_sel)) tgt = TGT_DSBY;
    else                          tgt = TGT_SSBY;
  end
endmodule

// File: rtl/lpm_irq_qual.sv
module lpm_irq_qual #(
  parameter int NIRQ = 4
) (
  input  logic [NIRQ-1:0] req,
  input  logic [NIRQ-1:0] masked,
  input  logic [NIRQ-1:0] to_dma,
  output logic            cpu_wake,
  output logic            amcs_wake
);
  logic [NIRQ-1:0] live;
  assign live      = req & ~masked;
  assign cpu_wake  = |live;
  assign amcs_wake = |(live & ~to_dma);
endmodule

// File: rtl/lpm_dswake.sv
module lpm_dswake #(
  parameter int NDS         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NDS-1:0] src,
  input  logic [NDS-1:0] edge_sel,
  input  logic [NDS-1:0] en,
  input  logic [NDS-1:0] flag_clr,
  output logic [NDS-1:0] flag,
  output logic           cancel
);
  for (genvar g = 0; g < NDS; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sh;
    logic                   prev;
    logic                   hit;
    logic                   flg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[SYNC_STAGES-2:0], src[g]};
        prev <= sh[SYNC_STAGES-1];
      end
    end

    assign hit = edge_sel[g] ? (sh[SYNC_STAGES-1] && !prev)
                             : (!sh[SYNC_STAGES-1] && prev);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flg <= 1'b0;
      else if (hit)        flg <= 1'b1;
      else if (flag_clr[g]) flg <= 1'b0;
    end

    assign flag[g] = flg;
  end

  assign cancel = |(flag & en);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq import lpm_pkg::*; #(
  parameter int NIRQ        = 4,
  parameter int NDS         = 4,
  parameter int MSB_W       = 32,
  parameter int MSC_HI_W    = 16,
  parameter int CNT_W       = 8,
  parameter int RST_LEN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wait_i,
  input  logic                sby_i,
  input  logic                dsby_i,
  input  logic                acs_en_i,
  input  logic [MSB_W-1:0]    mstop_b_i,
  input  logic [MSC_HI_W-1:0] mstop_c_hi_i,
  input  logic                ostd_en_i,
  input  logic                vm1_rst_sel_i,
  input  logic                vm2_rst_sel_i,
  input  logic [NIRQ-1:0]     irq_req_i,
  input  logic [NIRQ-1:0]     irq_masked_i,
  input  logic [NIRQ-1:0]     irq_to_dma_i,
  input  logic                rst_req_i,
  input  logic [CNT_W-1:0]    stab_cnt_i,
  input  logic [NDS-1:0]      ds_src_i,
  input  logic [NDS-1:0]      ds_edge_i,
  input  logic [NDS-1:0]      ds_en_i,
  input  logic [NDS-1:0]      ds_flag_clr_i,
  input  logic                ds_cause_clr_i,
  input  logic                iokeep_wr_i,
  input  logic                iokeep_wd_i,
  output logic                cpu_clk_en_o,
  output logic                per_clk_en_o,
  output logic                osc_en_o,
  output logic                core_pwr_en_o,
  output logic                ds_rst_o,
  output logic                io_hold_o,
  output logic                ds_cause_o,
  output logic [NDS-1:0]      ds_flag_o
);
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_LEN - 1);

  lpm_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  lpm_tgt_e         tgt;
  logic             cpu_wake, amcs_wake, ds_cancel;
  logic             iokeep_q, hold_q, cause_q;
  logic             ds_fire;

  lpm_select #(.MSB_W(MSB_W), .MSC_HI_W(MSC_HI_W)) u_sel (
    .sby(sby_i), .dsby(dsby_i), .acs_en(acs_en_i), .mstop_b(mstop_b_i),
    .mstop_c_hi(mstop_c_hi_i), .ostd_en(ostd_en_i), .vm1_sel(vm1_rst_sel_i),
    .vm2_sel(vm2_rst_sel_i), .tgt(tgt)
  );

  lpm_irq_qual #(.NIRQ(NIRQ)) u_irq (
    .req(irq_req_i), .masked(irq_masked_i), .to_dma(irq_to_dma_i),
    .cpu_wake(cpu_wake), .amcs_wake(amcs_wake)
  );

  lpm_dswake #(.NDS(NDS), .SYNC_STAGES(SYNC_STAGES)) u_ds (
    .clk(clk), .rst_n(rst_n), .src(ds_src_i), .edge_sel(ds_edge_i),
    .en(ds_en_i), .flag_clr(ds_flag_clr_i), .flag(ds_flag_o), .cancel(ds_cancel)
  );

  assign ds_fire = (state_q == ST_DSBY) && ds_cancel && !rst_req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (rst_req_i) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (wait_i) begin
          unique case (tgt)
            TGT_SLEEP: state_d = ST_SLEEP;
            TGT_AMCS:  state_d = ST_AMCS;
            TGT_SSBY:  state_d = ST_SSBY;
            TGT_DSBY:  state_d = ST_DSBY;
            default:   state_d = ST_RUN;
          endcase
        end
        ST_SLEEP: if (cpu_wake)  state_d = ST_RUN;
        ST_AMCS:  if (amcs_wake) state_d = ST_RUN;
        ST_SSBY:  if (cpu_wake) begin
          state_d = ST_SSTAB;
          cnt_d   = stab_cnt_i;
        end
        ST_SSTAB, ST_DSRST: begin
          if (cnt_q == '0) state_d = ST_RUN;
          else             cnt_d   = cnt_q - 1'b1;
        end
        ST_DSBY: if (ds_cancel) begin
          state_d = ST_DSRST;
          cnt_d   = RST_LOAD;
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      cnt_q    <= '0;
      iokeep_q <= 1'b0;
      hold_q   <= 1'b0;
      cause_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (iokeep_wr_i) iokeep_q <= iokeep_wd_i;
      if (ds_fire && iokeep_q) hold_q <= 1'b1;
      else if (!iokeep_q)      hold_q <= 1'b0;
      if (ds_fire)             cause_q <= 1'b1;
      else if (ds_cause_clr_i) cause_q <= 1'b0;
    end
  end

  assign cpu_clk_en_o  = (state_q == ST_RUN);
  assign per_clk_en_o  = (state_q == ST_RUN) || (state_q == ST_SLEEP);
  assign osc_en_o      = (state_q != ST_SSBY) && (state_q != ST_DSBY);
  assign core_pwr_en_o = (state_q != ST_DSBY);
  assign ds_rst_o      = (state_q == ST_DSRST);
  assign io_hold_o     = (state_q == ST_DSBY) || hold_q;
  assign ds_cause_o    = cause_q;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wait_i,
  input logic sby_i,
  input logic ostd_en_i,
  input logic rst_req_i,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic osc_en_o,
  input logic core_pwr_en_o,
  input logic ds_rst_o,
  input logic ds_cause_o,
  input logic io_hold_o,
  input logic iokeep_q
);
  assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && wait_i && !sby_i && !rst_req_i)
      |=> (!cpu_clk_en_o && osc_en_o && core_pwr_en_o));

  assert_ostd_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && wait_i && sby_i && ostd_en_i && !rst_req_i) |=> cpu_clk_en_o);

  assert_power_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en_o |-> (!osc_en_o && !per_clk_en_o && !cpu_clk_en_o && io_hold_o));

  assert_dsrst_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rst_o |-> (core_pwr_en_o && osc_en_o && !cpu_clk_en_o));

  assert_cause_on_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_rst_o) |-> ds_cause_o);

  assert_keep_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_rst_o && iokeep_q) |-> io_hold_o);

  assert_reset_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> cpu_clk_en_o);
endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wait_i(wait_i), .sby_i(sby_i),
  .ostd_en_i(ostd_en_i), .rst_req_i(rst_req_i), .cpu_clk_en_o(cpu_clk_en_o),
  .per_clk_en_o(per_clk_en_o), .osc_en_o(osc_en_o),
  .core_pwr_en_o(core_pwr_en_o), .ds_rst_o(ds_rst_o),
  .ds_cause_o(ds_cause_o), .io_hold_o(io_hold_o), .iokeep_q(iokeep_q)
);

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_i = 0, sby_i = 0, dsby_i = 0, acs_en_i = 0;
  logic [31:0] mstop_b_i = '0;
  logic [15:0] mstop_c_hi_i = '0;
  logic ostd_en_i = 0, vm1_rst_sel_i = 0, vm2_rst_sel_i = 0;
  logic [3:0] irq_req_i = '0, irq_masked_i = '0, irq_to_dma_i = '0;
  logic rst_req_i = 0;
  logic [7:0] stab_cnt_i = 8'd3;
  logic [3:0] ds_src_i = '0, ds_edge_i = '0, ds_en_i = '0, ds_flag_clr_i = '0;
  logic ds_cause_clr_i = 0, iokeep_wr_i = 0, iokeep_wd_i = 0;
  logic cpu_clk_en_o, per_clk_en_o, osc_en_o, core_pwr_en_o;
  logic ds_rst_o, io_hold_o, ds_cause_o;
  logic [3:0] ds_flag_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lpm_seq u_lpm_seq (.*);

  // vector: {sby, dsby, acs, b_full, c_full, ostd, vm1} , expected {cpu, per, osc, pwr}
  localparam logic [10:0] VEC [0:10] = '{
    {7'b0001100, 4'b0111},  // R1 plain sleep
    {7'b0011100, 4'b0011},  // R2 all conditions -> clock stop
    {7'b0010100, 4'b0111},  // R2 B not full -> sleep
    {7'b0011000, 4'b0111},  // R2 C half not full -> sleep
    {7'b0100000, 4'b0111},  // R1 deep bit ignored without standby
    {7'b0000010, 4'b0111},  // R1 osc-stop-detect does not block sleep
    {7'b1000000, 4'b0001},  // R3 software standby
    {7'b1000010, 4'b1111},  // R4 refused
    {7'b1100000, 4'b0000},  // R5 deep standby
    {7'b1100001, 4'b0001},  // R5 demoted by voltage monitor 1
    {7'b1100010, 4'b1111}   // R4 refused for deep too
  };

  function automatic logic [3:0] gates();
    return {cpu_clk_en_o, per_clk_en_o, osc_en_o, core_pwr_en_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_wait();
    wait_i = 1'b1;
    tick();
    wait_i = 1'b0;
  endtask

  task automatic kick_reset();
    rst_req_i = 1'b1;
    tick();
    rst_req_i = 1'b0;
  endtask

  task automatic set_cfg(input logic [6:0] c);
    sby_i = c[6]; dsby_i = c[5]; acs_en_i = c[4];
    mstop_b_i = c[3] ? 32'hFFFF_FFFF : 32'hFFFF_FFFE;
    mstop_c_hi_i = c[2] ? 16'hFFFF : 16'h7FFF;
    ostd_en_i = c[1]; vm1_rst_sel_i = c[0];
  endtask

  task automatic clear_flags();
    ds_flag_clr_i = 4'hF;
    tick();
    ds_flag_clr_i = 4'h0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("reset gates", 32'(gates()), 32'hF);
    chk("reset ds_rst/io_hold/cause", {ds_rst_o, io_hold_o, ds_cause_o}, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 11; i++) begin
      set_cfg(VEC[i][10:4]);
      do_wait();
      chk($sformatf("R1-R5 vector %0d", i), 32'(gates()), 32'(VEC[i][3:0]));
      if (VEC[i][3:0] == 4'b0000) chk("R5 io_hold in deep", 32'(io_hold_o), 1);
      kick_reset();
      chk($sformatf("R12 back to run %0d", i), 32'(gates()), 32'hF);
    end

    // R5 demotion by voltage monitor 2
    set_cfg(7'b1100000); vm2_rst_sel_i = 1'b1;
    do_wait();
    chk("R5 demoted by vm2", 32'(gates()), 32'h1);
    kick_reset(); vm2_rst_sel_i = 1'b0;

    // R6 masked interrupt in sleep
    set_cfg(7'b0000000);
    do_wait();
    irq_req_i = 4'b0010; irq_masked_i = 4'b0010;
    repeat (3) tick();
    chk("R6 masked keeps sleep", 32'(gates()), 32'h7);
    irq_masked_i = 4'b0000;
    tick();
    chk("R6 unmasked wakes sleep", 32'(gates()), 32'hF);
    irq_req_i = '0;

    // R6 masked interrupt in software standby
    set_cfg(7'b1000000);
    do_wait();
    irq_req_i = 4'b0001; irq_masked_i = 4'b0001;
    repeat (3) tick();
    chk("R6 masked keeps standby", 32'(gates()), 32'h1);
    irq_req_i = '0; irq_masked_i = '0;
    kick_reset();

    // R7 interrupt routed to DMA in clock stop
    set_cfg(7'b0011100);
    do_wait();
    irq_req_i = 4'b0100; irq_to_dma_i = 4'b0100;
    repeat (3) tick();
    chk("R7 dma-routed keeps clock stop", 32'(gates()), 32'h3);
    irq_to_dma_i = '0;
    tick();
    chk("R7 cpu-routed wakes clock stop", 32'(gates()), 32'hF);
    irq_req_i = '0;

    // R8 settling after software standby
    set_cfg(7'b1000000);
    do_wait();
    irq_req_i = 4'b1000;
    tick();
    irq_req_i = '0;
    chk("R8 osc on, cpu off start", 32'(gates()), 32'h3);
    repeat (3) tick();
    chk("R8 cpu still off last settle cycle", 32'(gates()), 32'h3);
    tick();
    chk("R8 run after stab+1", 32'(gates()), 32'hF);

    // R9 edge select and synchronizer latency
    set_cfg(7'b0000000);
    ds_edge_i = 4'b0001;
    ds_src_i[0] = 1'b1;
    tick(); tick();
    chk("R9 flag not yet after 2 edges", 32'(ds_flag_o), 0);
    tick();
    chk("R9 rising flag after 3 edges", 32'(ds_flag_o), 32'h1);
    ds_src_i[1] = 1'b1;
    repeat (4) tick();
    chk("R9 rise ignored when falling selected", 32'(ds_flag_o), 32'h1);
    ds_src_i[1] = 1'b0;
    repeat (3) tick();
    chk("R9 falling flag set", 32'(ds_flag_o), 32'h3);
    ds_src_i[0] = 1'b0;
    repeat (4) tick();
    clear_flags();
    chk("R9 clear strobe", 32'(ds_flag_o), 0);

    // R10 cancel only with enable
    ds_en_i = 4'b0001; ds_edge_i = 4'b0001;
    set_cfg(7'b1100000);
    do_wait();
    ds_src_i[1] = 1'b1;
    repeat (2) tick();
    ds_src_i[1] = 1'b0;
    repeat (5) tick();
    chk("R10 disabled flag latched", 32'(ds_flag_o[1]), 1);
    chk("R10 no cancel without enable", 32'(gates()), 0);
    ds_src_i[0] = 1'b1;
    repeat (3) tick();
    chk("R10 still deep before 4th edge", 32'(ds_rst_o), 0);
    tick();
    chk("R10 reset pulse starts", {ds_rst_o, core_pwr_en_o, osc_en_o, ds_cause_o}, 32'hF);
    repeat (3) tick();
    chk("R10 reset pulse last cycle", 32'(ds_rst_o), 1);
    tick();
    chk("R10 run after pulse", {ds_rst_o, cpu_clk_en_o}, 32'h1);
    chk("R11 no hold without keep", 32'(io_hold_o), 0);
    ds_cause_clr_i = 1'b1; tick(); ds_cause_clr_i = 1'b0;

    // R11 keep bit survives the deep standby reset
    ds_src_i[0] = 1'b0;
    repeat (4) tick();
    clear_flags();
    iokeep_wr_i = 1'b1; iokeep_wd_i = 1'b1; tick(); iokeep_wr_i = 1'b0;
    do_wait();
    chk("R11 hold in deep", 32'(io_hold_o), 1);
    ds_src_i[0] = 1'b1;
    repeat (8) tick();
    chk("R11 hold after release", {cpu_clk_en_o, io_hold_o, ds_cause_o}, 32'h7);
    repeat (3) tick();
    chk("R11 hold persists", 32'(io_hold_o), 1);
    iokeep_wr_i = 1'b1; iokeep_wd_i = 1'b0; tick(); iokeep_wr_i = 1'b0;
    tick();
    chk("R11 hold drops after clear", 32'(io_hold_o), 0);

    // R12 reset request from deep standby
    ds_src_i[0] = 1'b0;
    repeat (4) tick();
    clear_flags();
    do_wait();
    chk("R12 in deep", 32'(gates()), 0);
    kick_reset();
    chk("R12 deep left by reset request", 32'(gates()), 32'hF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule